// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the data-processing stage of a 32-bit integer core. Each cycle it receives two operands, a 5-bit operation code, a flag-setting enable and the current 32-bit status word. It produces a 32-bit result, a strobe that says whether the result should be written to the destination register, and the next status word. The second operand `b` arrives already shifted or rotated by an external shifter. That shifter also supplies its carry-out and a marker that says whether an immediate operand was rotated.

The supported operations are bitwise logic, add and three subtract forms, carry-chained variants of those, flag-only compare and test operations, and an insert into the upper half-word. The four condition flags live in the top nibble of the status word. The rest of the status word passes straight through.

The datapath is combinational. The result, the write strobe and the status word are captured on the rising clock edge. Reset is synchronous and active high.

Top module: `int_alu_flags`

## Requirements
- R1: In `status_out`, bit 31 is N, bit 30 is Z, bit 29 is C and bit 28 is V. Bits 27..0 of `status_out` always equal bits 27..0 of `status_in` from the cycle before.
- R2: When flags are updated, N equals bit 31 of the result and Z is 1 exactly when the result is zero.
- R3: Add (code 4) and compare-negative (code 11) compute a+b. C is the carry out of bit 31 and V is the signed overflow of that sum.
- R4: Subtract (code 2) and compare (code 10) compute a-b. C is 1 when no borrow occurs (a >= b unsigned) and V is the signed overflow of the difference.
- R5: Reverse subtract (code 3) computes b-a. C is 1 when b >= a unsigned and V is the signed overflow of b-a.
- R6: The carry-chained forms all use the old carry Cin (status_in bit 29) and the flag rules of their base operation:
  - add-with-carry (code 5) computes a+b+Cin;
  - subtract-with-carry (code 6) computes a-b-(1-Cin);
  - reverse-subtract-with-carry (code 7) computes b-a-(1-Cin).
- R7: The logical operations and their results are:
  - and (code 0): a&b;
  - xor (code 1): a^b;
  - or (code 12): a|b;
  - or-not (code 13): a|~b;
  - bit-clear (code 15): a&~b;
  - move (code 14): b;
  - move-not (code 16): ~b.
  
  When flags are updated, V keeps its old value.
- R8: For logical operations and move-top, C is taken as follows:
  - when `imm_mode`=0, C is `shift_cout`;
  - when `imm_mode`=1 and `imm_rot`=1, C is b[31];
  - when `imm_mode`=1 and `imm_rot`=0, C keeps its old value.
- R9: Test (code 8, a&b), test-equal (code 9, a^b), compare and compare-negative drive their computed value on `result` and update flags, but `wr_dest` stays 0.
- R10: Move-top (code 17) returns {b[15:0], a[15:0]} and follows the logical flag rules.
- R11: When `set_flags`=0, `status_out` equals `status_in` from the cycle before, for every code.
- R12: Codes 18 to 31 give a zero result and `wr_dest`=0, and leave the status word unchanged even when `set_flags`=1.
- R13: Outputs are registered, so they reflect the inputs one rising edge earlier. A synchronous reset clears `result`, `wr_dest` and `status_out` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 5 | Operation code |
| set_flags | input | 1 | Update N, Z, C, V when 1 |
| imm_mode | input | 1 | Second operand is an immediate |
| imm_rot | input | 1 | Immediate rotation was applied |
| shift_cout | input | 1 | Carry-out of the external shifter |
| a | input | 32 | First operand |
| b | input | 32 | Second operand, already shifted |
| status_in | input | 32 | Current status word |
| result | output | 32 | Registered result |
| wr_dest | output | 1 | Registered destination write strobe |
| status_out | output | 32 | Registered next status word |

## Verification
The carry-chained forms read the old C and produce a new C in the same cycle. The tests therefore feed them inputs whose old carry changes the arithmetic outcome, for example a borrow that appears only when Cin is 0. Each result is judged against a separately computed unsigned and signed model.

Flag update and write suppression also coincide in one cycle for the compare and test codes. These are driven with results of zero and negative values, and the bench checks that Z and N move while `wr_dest` stays low.

// File: rtl/int_alu_flags.sv
module int_alu_flags #(
  parameter int W   = 32,
  parameter int OPW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] op_sel,
  input  logic           set_flags,
  input  logic           imm_mode,
  input  logic           imm_rot,
  input  logic           shift_cout,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [31:0]    status_in,
  output logic [W-1:0]   result,
  output logic           wr_dest,
  output logic [31:0]    status_out
);
  localparam int HW = W / 2;
  localparam logic [OPW-1:0] OP_AND = 0,  OP_XOR = 1,  OP_SUB = 2,  OP_RSB = 3,
                             OP_ADD = 4,  OP_ADC = 5,  OP_SBC = 6,  OP_RSC = 7,
                             OP_TST = 8,  OP_TEQ = 9,  OP_CMP = 10, OP_CMN = 11,
                             OP_ORR = 12, OP_ORN = 13, OP_MOV = 14, OP_BIC = 15,
                             OP_MVN = 16, OP_MVT = 17;

  logic          c_old, v_old;
  logic [W-1:0]  ax, by, res;
  logic          cin, arith, valid, nowr;
  logic [W:0]    sum;
  logic          c_logic, n_f, z_f, c_f, v_f;
  logic [31:0]   st_next;

  assign c_old = status_in[29];
  assign v_old = status_in[28];

  always_comb begin
    ax = a; by = b; cin = 1'b0; arith = 1'b0;
    unique case (op_sel)
      OP_ADD, OP_CMN: begin arith = 1'b1; end
      OP_ADC:         begin arith = 1'b1; cin = c_old; end
      OP_SUB, OP_CMP: begin arith = 1'b1; by = ~b; cin = 1'b1; end
      OP_SBC:         begin arith = 1'b1; by = ~b; cin = c_old; end
      OP_RSB:         begin arith = 1'b1; ax = b; by = ~a; cin = 1'b1; end
      OP_RSC:         begin arith = 1'b1; ax = b; by = ~a; cin = c_old; end
      default: ;
    endcase
  end

  assign sum = {1'b0, ax} + {1'b0, by} + {{W{1'b0}}, cin};

  always_comb begin
    unique case (op_sel)
      OP_AND, OP_TST: res = a & b;
      OP_XOR, OP_TEQ: res = a ^ b;
      OP_ORR:         res = a | b;
      OP_ORN:         res = a | ~b;
      OP_BIC:         res = a & ~b;
      OP_MOV:         res = b;
      OP_MVN:         res = ~b;
      OP_MVT:         res = {b[HW-1:0], a[HW-1:0]};
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_RSB, OP_RSC, OP_CMP, OP_CMN:
                      res = sum[W-1:0];
      default:        res = '0;
    endcase
  end

  assign valid   = (op_sel <= OP_MVT);
  assign nowr    = (op_sel == OP_TST) || (op_sel == OP_TEQ) ||
                   (op_sel == OP_CMP) || (op_sel == OP_CMN);
  assign c_logic = imm_mode ? (imm_rot ? b[W-1] : c_old) : shift_cout;

  assign n_f = res[W-1];
  assign z_f = (res == '0);
  assign c_f = arith ? sum[W] : c_logic;
  assign v_f = arith ? ((ax[W-1] == by[W-1]) && (sum[W-1] != ax[W-1])) : v_old;

  assign st_next = (set_flags && valid) ? {n_f, z_f, c_f, v_f, status_in[27:0]}
                                        : status_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      result     <= '0;
      wr_dest    <= 1'b0;
      status_out <= '0;
    end else begin
      result     <= res;
      wr_dest    <= valid && !nowr;
      status_out <= st_next;
    end
  end
endmodule

// File: rtl/int_alu_flags_chk.sv
module int_alu_flags_chk (
  input logic        clk,
  input logic        rst,
  input logic [4:0]  op_sel,
  input logic        set_flags,
  input logic [31:0] a,
  input logic [31:0] b,
  input logic [31:0] status_in,
  input logic [31:0] result,
  input logic        wr_dest,
  input logic [31:0] status_out
);
  logic is_logic, is_cmp;
  assign is_logic = (op_sel <= 5'd1) || ((op_sel >= 5'd12) && (op_sel <= 5'd17));
  assign is_cmp   = (op_sel >= 5'd8) && (op_sel <= 5'd11);

  AST_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> status_out[27:0] == $past(status_in[27:0])); // R1
  AST_NZ_MATCH: assert property (@(posedge clk) disable iff (rst)
    (set_flags && op_sel <= 5'd17) |=> (status_out[31] == result[31]) && (status_out[30] == (result == 32'd0))); // R2
  AST_LOGIC_V: assert property (@(posedge clk) disable iff (rst)
    (set_flags && is_logic) |=> status_out[28] == $past(status_in[28])); // R7
  AST_TEST_NOWR: assert property (@(posedge clk) disable iff (rst)
    is_cmp |=> !wr_dest); // R9
  AST_TOP_INSERT: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 5'd17) |=> result == {$past(b[15:0]), $past(a[15:0])}); // R10
  AST_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    !set_flags |=> status_out == $past(status_in)); // R11
  AST_BAD_CODE: assert property (@(posedge clk) disable iff (rst)
    (op_sel > 5'd17) |=> (result == 32'd0) && !wr_dest && status_out == $past(status_in)); // R12
  AST_RESET_CLR: assert property (@(posedge clk)
    rst |=> (result == 32'd0) && !wr_dest && (status_out == 32'd0)); // R13
endmodule

bind int_alu_flags int_alu_flags_chk u_chk (
  .clk(clk), .rst(rst), .op_sel(op_sel), .set_flags(set_flags),
  .a(a), .b(b), .status_in(status_in), .result(result),
  .wr_dest(wr_dest), .status_out(status_out)
);

// File: tb/sim_int_alu_flags.sv
module sim_int_alu_flags;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_sel = '0;
  logic        set_flags = 1'b0, imm_mode = 1'b0, imm_rot = 1'b0, shift_cout = 1'b0;
  logic [31:0] a = '0, b = '0, status_in = '0;
  logic [31:0] result, status_out;
  logic        wr_dest;
  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  int_alu_flags u0 (
    .clk(clk), .rst(rst), .op_sel(op_sel), .set_flags(set_flags),
    .imm_mode(imm_mode), .imm_rot(imm_rot), .shift_cout(shift_cout),
    .a(a), .b(b), .status_in(status_in), .result(result),
    .wr_dest(wr_dest), .status_out(status_out)
  );

  function automatic logic [64:0] model(input logic [4:0] op, input logic sf,
      input logic im, input logic rt, input logic sc,
      input logic [31:0] x, input logic [31:0] y, input logic [31:0] st);
    longint sx, sy, ux, uy, s;
    logic [31:0] r;
    logic c, v, wr, ar, cold, bw;
    sx = longint'($signed(x)); sy = longint'($signed(y));
    ux = longint'({32'd0, x}); uy = longint'({32'd0, y});
    cold = st[29]; bw = ~cold;
    c = im ? (rt ? y[31] : cold) : sc;
    v = st[28]; ar = 1'b1; s = 0; wr = 1'b1;
    case (op)
      4, 11: begin r = x + y; c = (ux + uy) > 64'hFFFFFFFF; s = sx + sy; end
      5:     begin r = x + y + {31'd0, cold}; c = (ux + uy + longint'(cold)) > 64'hFFFFFFFF;
                   s = sx + sy + longint'(cold); end
      2, 10: begin r = x - y; c = ux >= uy; s = sx - sy; end
      6:     begin r = x - y - {31'd0, bw}; c = ux >= uy + longint'(bw);
                   s = sx - sy - longint'(bw); end
      3:     begin r = y - x; c = uy >= ux; s = sy - sx; end
      7:     begin r = y - x - {31'd0, bw}; c = uy >= ux + longint'(bw);
                   s = sy - sx - longint'(bw); end
      default: begin
        ar = 1'b0;
        case (op)
          0, 8:  r = x & y;
          1, 9:  r = x ^ y;
          12:    r = x | y;
          13:    r = x | ~y;
          14:    r = y;
          15:    r = x & ~y;
          16:    r = ~y;
          17:    r = {y[15:0], x[15:0]};
          default: r = 32'd0;
        endcase
      end
    endcase
    if (ar) v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    if (op >= 8 && op <= 11) wr = 1'b0;
    if (op > 17) wr = 1'b0;
    if (sf && op <= 17) model = {wr, r[31], (r == 0), c, v, st[27:0], r};
    else                model = {wr, st, r};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [4:0] op, input logic sf,
      input logic im, input logic rt, input logic sc,
      input logic [31:0] x, input logic [31:0] y, input logic [31:0] st);
    logic [64:0] e;
    @(negedge clk);
    op_sel = op; set_flags = sf; imm_mode = im; imm_rot = rt; shift_cout = sc;
    a = x; b = y; status_in = st;
    e = model(op, sf, im, rt, sc, x, y, st);
    @(negedge clk);
    check(req, "result", result, e[31:0]);
    check(req, "status", status_out, e[63:32]);
    check(req, "wr_dest", {31'd0, wr_dest}, {31'd0, e[64]});
  endtask

  task automatic t_reset;
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R13", "reset result", result, 32'd0);
    check("R13", "reset status", status_out, 32'd0);
    check("R13", "reset wr", {31'd0, wr_dest}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_add_flags;
    run("R3", 5'd4, 1, 0, 0, 0, 32'h7FFFFFFF, 32'h00000001, 32'h0ABCDEF1);
    run("R3", 5'd4, 1, 0, 0, 0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000);
    run("R3", 5'd4, 1, 0, 0, 0, 32'h80000000, 32'h80000000, 32'h00000000);
    run("R2", 5'd4, 1, 0, 0, 0, 32'h00001234, 32'h00000010, 32'hF0000000);
  endtask

  task automatic t_sub_flags;
    run("R4", 5'd2, 1, 0, 0, 0, 32'h00000005, 32'h00000003, 32'h00000000);
    run("R4", 5'd2, 1, 0, 0, 0, 32'h00000003, 32'h00000005, 32'h20000000);
    run("R4", 5'd2, 1, 0, 0, 0, 32'h80000000, 32'h00000001, 32'h00000000);
    run("R4", 5'd2, 1, 0, 0, 0, 32'h12345678, 32'h12345678, 32'h00000000);
  endtask

  task automatic t_reverse;
    run("R5", 5'd3, 1, 0, 0, 0, 32'h00000003, 32'h00000010, 32'h00000000);
    run("R5", 5'd3, 1, 0, 0, 0, 32'h00000010, 32'h00000003, 32'h00000000);
    run("R5", 5'd3, 1, 0, 0, 0, 32'h00000001, 32'h80000000, 32'h00000000);
  endtask

  task automatic t_carry_chain;
    run("R6", 5'd5, 1, 0, 0, 0, 32'hFFFFFFFF, 32'h00000000, 32'h20000000);
    run("R6", 5'd5, 1, 0, 0, 0, 32'hFFFFFFFF, 32'h00000000, 32'h00000000);
    run("R6", 5'd6, 1, 0, 0, 0, 32'h00000005, 32'h00000005, 32'h00000000);
    run("R6", 5'd6, 1, 0, 0, 0, 32'h00000005, 32'h00000005, 32'h20000000);
    run("R6", 5'd7, 1, 0, 0, 0, 32'h00000002, 32'h00000002, 32'h00000000);
    run("R6", 5'd7, 1, 0, 0, 0, 32'h00000001, 32'h80000000, 32'h20000000);
  endtask

  task automatic t_logic;
    run("R7", 5'd0,  1, 0, 0, 1, 32'hF0F0F0F0, 32'hFF00FF00, 32'h10000000);
    run("R7", 5'd1,  1, 0, 0, 0, 32'hAAAA5555, 32'hAAAA5555, 32'h10000000);
    run("R7", 5'd12, 1, 0, 0, 0, 32'h00000001, 32'h80000000, 32'h00000000);
    run("R7", 5'd13, 1, 0, 0, 1, 32'h00000000, 32'hFFFF0000, 32'h10000000);
    run("R7", 5'd14, 1, 0, 0, 0, 32'h12345678, 32'h00000000, 32'h00000000);
    run("R7", 5'd15, 1, 0, 0, 0, 32'hFFFFFFFF, 32'h0F0F0F0F, 32'h10000000);
    run("R7", 5'd16, 1, 0, 0, 1, 32'h00000000, 32'h00000000, 32'h00000000);
  endtask

  task automatic t_logic_carry;
    run("R8", 5'd14, 1, 0, 0, 1, 32'h0, 32'h00000007, 32'h00000000);
    run("R8", 5'd14, 1, 0, 0, 0, 32'h0, 32'h00000007, 32'h20000000);
    run("R8", 5'd14, 1, 1, 1, 0, 32'h0, 32'h80000000, 32'h00000000);
    run("R8", 5'd14, 1, 1, 1, 1, 32'h0, 32'h00000001, 32'h20000000);
    run("R8", 5'd14, 1, 1, 0, 0, 32'h0, 32'h80000000, 32'h20000000);
    run("R8", 5'd14, 1, 1, 0, 1, 32'h0, 32'h80000000, 32'h00000000);
  endtask

  task automatic t_compare;
    run("R9", 5'd8,  1, 0, 0, 0, 32'h0000FF00, 32'h000000FF, 32'h00000000);
    run("R9", 5'd9,  1, 0, 0, 0, 32'h80000001, 32'h00000001, 32'h00000000);
    run("R9", 5'd10, 1, 0, 0, 0, 32'h00000007, 32'h00000007, 32'h00000000);
    run("R9", 5'd11, 1, 0, 0, 0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000);
    run("R9", 5'd10, 0, 0, 0, 0, 32'h00000001, 32'h00000002, 32'h50000000);
  endtask

  task automatic t_top_insert;
    run("R10", 5'd17, 1, 0, 0, 1, 32'hDEADBEEF, 32'h12345678, 32'h00000000);
    run("R10", 5'd17, 0, 0, 0, 0, 32'h0000ABCD, 32'hFFFF0000, 32'h00000000);
  endtask

  task automatic t_no_flags;
    run("R11", 5'd4,  0, 0, 0, 0, 32'hFFFFFFFF, 32'h00000001, 32'h9ABCDEF0);
    run("R11", 5'd2,  0, 0, 0, 1, 32'h00000000, 32'h00000001, 32'h00000000);
    run("R11", 5'd14, 0, 1, 1, 0, 32'h00000000, 32'h80000000, 32'h1234ABCD);
  endtask

  task automatic t_bad_code;
    run("R12", 5'd18, 1, 0, 0, 1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hA5A5A5A5);
    run("R12", 5'd31, 1, 1, 1, 0, 32'h12345678, 32'h87654321, 32'h00000000);
  endtask

  task automatic t_low_bits;
    run("R1", 5'd4, 1, 0, 0, 0, 32'h80000000, 32'h80000000, 32'h0FFFFFFF);
    run("R1", 5'd0, 1, 0, 0, 1, 32'h80000000, 32'h80000000, 32'h05A5A5A5);
  endtask

  task automatic t_reset_midstream;
    @(negedge clk);
    op_sel = 5'd4; set_flags = 1'b1; a = 32'h80000000; b = 32'h80000000;
    status_in = 32'hFFFFFFFF; rst = 1'b1;
    @(negedge clk);
    check("R13", "mid reset result", result, 32'd0);
    check("R13", "mid reset status", status_out, 32'd0);
    rst = 1'b0;
  endtask

  initial begin
    t_reset();
    t_add_flags();
    t_sub_flags();
    t_reverse();
    t_carry_chain();
    t_logic();
    t_logic_carry();
    t_compare();
    t_top_insert();
    t_no_flags();
    t_bad_code();
    t_low_bits();
    t_reset_midstream();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule